// File: doc/BRIEF.md
# Serial Port Register Bank with Interrupt Identification

This block is the host-visible register set of a 16450-style serial port. A host reaches eight byte-wide registers through a 3-bit offset, a write strobe and a read strobe. The character side is parallel and has no timing of its own. A write to the data register leaves the block at once as a one-cycle byte strobe. Incoming bytes arrive over a valid/ready handshake and wait in a single-entry holding register. A break input stands for a received line break. One level output tells the host that an enabled condition is pending.

Two small state machines keep the stateful part of the behaviour. The receive holder has the states RX_EMPTY and RX_FULL. It moves RX_EMPTY→RX_FULL when it accepts a byte or sees a break. It moves RX_FULL→RX_EMPTY when the host reads the data register. A break arriving in RX_FULL keeps it in RX_FULL and reloads the holder. The transmit-pending tracker has the states TXP_IDLE and TXP_ARMED. It moves to TXP_ARMED on a data-register write or an enable-register write. It moves TXP_ARMED→TXP_IDLE when the host reads the identification register while that register shows the transmit code. If an arming event and that read fall in the same cycle, the arming event wins.

The identification value and the interrupt output are computed combinationally from these states and the enable bits. A change caused by any strobe therefore shows in the cycle after that strobe.

Top module: `uart_regbank`

## Requirements
- R1: After reset, line status (offset 5) reads 0x60 and identification (offset 2) reads 0x01. The interrupt output is low and rx_ready is high.
- R2: While bit 7 of the line-control register (offset 3, read/write, all 8 bits kept) is set, offsets 0 and 1 read and write the low and high divisor bytes. In that mode a write to offset 0 produces no transmit strobe, and a read of offset 0 leaves receive status unchanged.
- R3: A write to the enable register (offset 1, divisor access clear) keeps only bits 3:0. A write to modem control (offset 4) keeps only bits 4:0.
- R4: Identification reads 0x04 when data-ready is set and enable bit 0 is set. Otherwise it reads 0x02 when transmit is pending and enable bit 1 is set. Otherwise it reads 0x01. The interrupt output is high exactly when identification is not 0x01.
- R5: A write to offset 0 with divisor access clear pulses tx_valid for one cycle with tx_byte equal to the written byte. It arms transmit-pending, and line status bits 6 and 5 stay set.
- R6: A read of offset 2 that returns 0x02 disarms transmit-pending. A read that returns any other code leaves it unchanged.
- R7: Any write to the enable register arms transmit-pending, because the holding-empty bit is always set.
- R8: A read of offset 0 with divisor access clear returns the held byte and clears data-ready (line status bit 0) and break (bit 4).
- R9: rx_ready equals the inverse of data-ready. A byte is taken only when rx_valid and rx_ready are both high; taking it sets data-ready. While data-ready is set, rx_valid is ignored and the held byte is kept.
- R10: A cycle with brk_evt high loads 0x00 into the holder and sets both break and data-ready, whatever the holder state.
- R11: When modem-control bit 4 is set, offset 6 reads control bits 3:2 in bits 7:6, control bit 0 in bit 5 and control bit 1 in bit 4, with bits 3:0 zero.
- R12: Writes to offsets 2 and 5 have no effect. Offset 6 stores a written byte as the modem status returned when loopback is off. Offset 7 is a plain 8-bit scratch register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_rdata | output | 8 | Read data for the offset, valid during the read cycle |
| tx_valid | output | 1 | One-cycle strobe for a transmitted byte |
| tx_byte | output | 8 | Transmitted byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_byte | input | 8 | Receive byte |
| rx_ready | output | 1 | Holder can take a byte |
| brk_evt | input | 1 | Line break received |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest state to reach from the ports is a transmit-pending flag that survives a read of the identification register. That happens only when a receive-data condition of higher priority hides it. The stimulus first fills the holder with a byte and enables both interrupts. It then writes a transmit byte, reads identification and expects 0x04. Only after the held byte is drained does it expect 0x02, which shows that the earlier read left the flag armed. Break-versus-byte priority, and divisor-mode reads that must not drain the holder, are reached the same way: the holder is held full before the competing strobe is applied.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int DIV_W  = 2 * DATA_W;
    localparam int IER_W  = 4;
    localparam int MCR_W  = 5;

    localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_IID  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_LCTL = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_MCTL = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_LSTA = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_MSTA = 3'd6;
    localparam logic [ADDR_W-1:0] OFS_SCR  = 3'd7;

    localparam logic [DATA_W-1:0] IID_NONE = 8'h01;
    localparam logic [DATA_W-1:0] IID_TXE  = 8'h02;
    localparam logic [DATA_W-1:0] IID_RXD  = 8'h04;

    localparam int LCTL_DIVBIT = 7;
    localparam int MCTL_LOOP   = 4;

    typedef enum logic {RX_EMPTY, RX_FULL} rx_state_e;
    typedef enum logic {TXP_IDLE, TXP_ARMED} txp_state_e;
endpackage

// File: rtl/uart_rb_rx.sv
module uart_rb_rx
    import uart_rb_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_byte,
    input  logic         brk_evt,
    input  logic         hold_rd,
    output logic [W-1:0] hold_byte,
    output logic         data_rdy,
    output logic         brk_flag,
    output logic         rx_ready
);
    rx_state_e state_q, state_d;
    logic [W-1:0] byte_q, byte_d;
    logic brk_q, brk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_EMPTY;
            byte_q  <= '0;
            brk_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            byte_q  <= byte_d;
            brk_q   <= brk_d;
        end
    end

    always_comb begin
        state_d = state_q;
        byte_d  = byte_q;
        brk_d   = brk_q;
        unique case (state_q)
            RX_EMPTY: begin
                if (brk_evt) begin
                    state_d = RX_FULL;
                    byte_d  = '0;
                    brk_d   = 1'b1;
                end else if (rx_valid) begin
                    state_d = RX_FULL;
                    byte_d  = rx_byte;
                end
            end
            RX_FULL: begin
                if (brk_evt) begin
                    byte_d = '0;
                    brk_d  = 1'b1;
                end else if (hold_rd) begin
                    state_d = RX_EMPTY;
                    brk_d   = 1'b0;
                end
            end
            default: state_d = RX_EMPTY;
        endcase
    end

    assign hold_byte = byte_q;
    assign data_rdy  = (state_q == RX_FULL);
    assign brk_flag  = brk_q;
    assign rx_ready  = (state_q == RX_EMPTY);

    // R9: a held byte is not overwritten by offered bytes
    a_r9_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rdy && !brk_evt) |=> (hold_byte == $past(hold_byte)));
    // R8: reading the holder drains it unless a break lands
    a_r8_read_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rdy && hold_rd && !brk_evt) |=> (!data_rdy && !brk_flag));
    // R10: a break always leaves zero held with both flags
    a_r10_break_load: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |=> (data_rdy && brk_flag && hold_byte == '0));
endmodule

// File: rtl/uart_rb_txp.sv
module uart_rb_txp
    import uart_rb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_thr,
    input  logic arm_ien,
    input  logic iid_tx_rd,
    output logic tx_pend
);
    txp_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TXP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXP_IDLE:  if (arm_thr || arm_ien) state_d = TXP_ARMED;
            TXP_ARMED: if (iid_tx_rd && !arm_thr && !arm_ien) state_d = TXP_IDLE;
            default:   state_d = TXP_IDLE;
        endcase
    end

    assign tx_pend = (state_q == TXP_ARMED);

    // R5 / R7: arming events always leave the flag set
    a_r5_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_thr || arm_ien) |=> tx_pend);
    // R6: an identification read showing the transmit code disarms
    a_r6_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (iid_tx_rd && !arm_thr && !arm_ien) |=> !tx_pend);
endmodule

// File: rtl/uart_rb_irq.sv
module uart_rb_irq
    import uart_rb_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         data_rdy,
    input  logic         tx_pend,
    input  logic         en_rx,
    input  logic         en_tx,
    output logic [W-1:0] iid,
    output logic         irq
);
    always_comb begin
        if (data_rdy && en_rx)      iid = IID_RXD;
        else if (tx_pend && en_tx)  iid = IID_TXE;
        else                        iid = IID_NONE;
    end

    assign irq = (iid != IID_NONE);

    // R4: a receive condition always outranks the transmit one
    always_comb begin
        if (data_rdy && en_rx)
            a_r4_rx_first: assert (iid != IID_TXE);
    end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_rb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_wr,
    input  logic        bus_rd,
    output logic [7:0]  bus_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    output logic        rx_ready,
    input  logic        brk_evt,
    output logic        irq
);
    logic [DATA_W-1:0] lctl_q, msta_q, scr_q;
    logic [DIV_W-1:0]  div_q;
    logic [IER_W-1:0]  ien_q;
    logic [MCR_W-1:0]  mctl_q;

    logic div_mode;
    logic wr_data, wr_ien, wr_divlo, wr_divhi;
    logic rd_hold, rd_iid;
    logic [DATA_W-1:0] hold_byte, iid, lsta, msta_view;
    logic data_rdy, brk_flag, tx_pend, rx_take;

    assign div_mode = lctl_q[LCTL_DIVBIT];
    assign wr_data  = bus_wr && bus_addr == OFS_DATA && !div_mode;
    assign wr_divlo = bus_wr && bus_addr == OFS_DATA &&  div_mode;
    assign wr_ien   = bus_wr && bus_addr == OFS_IEN  && !div_mode;
    assign wr_divhi = bus_wr && bus_addr == OFS_IEN  &&  div_mode;
    assign rd_hold  = bus_rd && bus_addr == OFS_DATA && !div_mode;
    assign rd_iid   = bus_rd && bus_addr == OFS_IID;
    assign rx_take  = rx_valid && rx_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lctl_q <= '0;
            msta_q <= '0;
            scr_q  <= '0;
            div_q  <= '0;
            ien_q  <= '0;
            mctl_q <= '0;
        end else begin
            if (wr_divlo) div_q[DATA_W-1:0]     <= bus_wdata;
            if (wr_divhi) div_q[DIV_W-1:DATA_W] <= bus_wdata;
            if (wr_ien)   ien_q                 <= bus_wdata[IER_W-1:0];
            if (bus_wr) begin
                unique case (bus_addr)
                    OFS_LCTL: lctl_q <= bus_wdata;
                    OFS_MCTL: mctl_q <= bus_wdata[MCR_W-1:0];
                    OFS_MSTA: msta_q <= bus_wdata;
                    OFS_SCR:  scr_q  <= bus_wdata;
                    default:  ;
                endcase
            end
        end
    end

    uart_rb_rx #(.W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_take), .rx_byte(rx_byte), .brk_evt(brk_evt),
        .hold_rd(rd_hold), .hold_byte(hold_byte), .data_rdy(data_rdy),
        .brk_flag(brk_flag), .rx_ready(rx_ready)
    );

    uart_rb_txp u_txp (
        .clk(clk), .rst_n(rst_n),
        .arm_thr(wr_data), .arm_ien(wr_ien),
        .iid_tx_rd(rd_iid && iid == IID_TXE),
        .tx_pend(tx_pend)
    );

    uart_rb_irq #(.W(DATA_W)) u_irq (
        .data_rdy(data_rdy), .tx_pend(tx_pend),
        .en_rx(ien_q[0]), .en_tx(ien_q[1]),
        .iid(iid), .irq(irq)
    );

    assign lsta = {1'b0, 1'b1, 1'b1, brk_flag, 3'b000, data_rdy};
    assign msta_view = mctl_q[MCTL_LOOP]
        ? {mctl_q[3], mctl_q[2], mctl_q[0], mctl_q[1], 4'b0000}
        : msta_q;

    always_comb begin
        unique case (bus_addr)
            OFS_DATA: bus_rdata = div_mode ? div_q[DATA_W-1:0] : hold_byte;
            OFS_IEN:  bus_rdata = div_mode ? div_q[DIV_W-1:DATA_W]
                                           : {{(DATA_W-IER_W){1'b0}}, ien_q};
            OFS_IID:  bus_rdata = iid;
            OFS_LCTL: bus_rdata = lctl_q;
            OFS_MCTL: bus_rdata = {{(DATA_W-MCR_W){1'b0}}, mctl_q};
            OFS_LSTA: bus_rdata = lsta;
            OFS_MSTA: bus_rdata = msta_view;
            default:  bus_rdata = scr_q;
        endcase
    end

    assign tx_valid = wr_data;
    assign tx_byte  = bus_wdata;

    // R2: divisor-mode writes never emit a transmit strobe
    a_r2_no_tx_in_div: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && div_mode) |-> !tx_valid);
    // R9: handshake ready tracks the holder being empty
    a_r9_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready == !lsta[0]);
    // R3: kept enable bits come only from the written nibble
    a_r3_ien_mask: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ien |=> (ien_q == $past(bus_wdata[IER_W-1:0])));
    // R12: writes at offset 5 leave the break/ready status untouched
    a_r12_lsta_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_LSTA && !brk_evt && !rx_take && !bus_rd)
        |=> $stable(lsta));
endmodule

// File: tb/uart_regbank_tb.sv
module uart_regbank_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic tx_valid;
    logic [7:0] tx_byte;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic rx_ready, brk_evt = 1'b0, irq;

    int checks = 0, errors = 0;
    bit dlab_shadow = 1'b0;
    bit done = 1'b0;

    logic [7:0] rd_exp_q[$];
    string      rd_tag_q[$];
    logic [7:0] tx_exp_q[$];

    always #10 clk = ~clk;

    uart_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_ready(rx_ready), .brk_evt(brk_evt), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: compares read data and transmit strobes against the queues
    always @(negedge clk) begin
        if (bus_rd) begin
            if (rd_exp_q.size() == 0) check(0, "read-unexpected", bus_rdata, 0);
            else begin
                automatic logic [7:0] e = rd_exp_q.pop_front();
                automatic string t = rd_tag_q.pop_front();
                check(bus_rdata == e, t, bus_rdata, e);
            end
        end
        if (tx_valid) begin
            if (tx_exp_q.size() == 0) check(0, "R2 unexpected tx", tx_byte, 0);
            else begin
                automatic logic [7:0] e = tx_exp_q.pop_front();
                check(tx_byte == e, "R5 tx byte", tx_byte, e);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        if (a == 3'd0 && !dlab_shadow) tx_exp_q.push_back(d);
        if (a == 3'd3) dlab_shadow = d[7];
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        @(posedge clk); #2;
        rd_exp_q.push_back(e); rd_tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #2;
        bus_rd = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        @(posedge clk); #2;
        rx_byte = b; rx_valid = 1'b1;
        @(posedge clk); #2;
        rx_valid = 1'b0;
    endtask

    task automatic brk();
        @(posedge clk); #2;
        brk_evt = 1'b1;
        @(posedge clk); #2;
        brk_evt = 1'b0;
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(rx_ready == 1'b1, "R1 rx_ready", rx_ready, 1);
        rd(3'd5, 8'h60, "R1 line status");
        rd(3'd2, 8'h01, "R1 identification");

        // R2 divisor access
        wr(3'd3, 8'h80);
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h12);
        rd(3'd0, 8'h34, "R2 divisor low");
        rd(3'd1, 8'h12, "R2 divisor high");
        rd(3'd3, 8'h80, "R2 line control");
        wr(3'd3, 8'h03);
        rd(3'd3, 8'h03, "R2 line control cleared");
        check(irq == 1'b0, "R2 no arm from divisor", irq, 0);

        // R3 / R7 / R6
        wr(3'd1, 8'hFF);
        check(irq == 1'b1, "R7 enable write arms", irq, 1);
        rd(3'd1, 8'h0F, "R3 enable mask");
        wr(3'd4, 8'hFF);
        rd(3'd4, 8'h1F, "R3 modem control mask");
        rd(3'd2, 8'h02, "R6 reads tx code");
        check(irq == 1'b0, "R6 irq drops", irq, 0);
        rd(3'd2, 8'h01, "R6 disarmed");

        // R11 loopback remap
        rd(3'd6, 8'hF0, "R11 loop all");
        wr(3'd4, 8'h16);
        rd(3'd6, 8'h50, "R11 loop bits 2,1");
        wr(3'd4, 8'h09);
        wr(3'd6, 8'h5A);
        rd(3'd6, 8'h5A, "R12 stored modem status");
        wr(3'd4, 8'h19);
        rd(3'd6, 8'hA0, "R11 loop bits 3,0");

        // R12 scratch and read-only offsets
        wr(3'd7, 8'hC3);
        rd(3'd7, 8'hC3, "R12 scratch");
        wr(3'd5, 8'h00);
        rd(3'd5, 8'h60, "R12 line status ignores write");
        wr(3'd2, 8'hFF);
        rd(3'd2, 8'h01, "R12 identification ignores write");

        // R9 / R4 / R5 / R6 / R8: hidden pending behind receive priority
        send(8'hA5);
        @(negedge clk);
        check(rx_ready == 1'b0, "R9 ready low when full", rx_ready, 0);
        check(irq == 1'b1, "R4 irq on receive", irq, 1);
        rd(3'd5, 8'h61, "R9 data ready set");
        send(8'h77);
        wr(3'd0, 8'h3C);
        rd(3'd5, 8'h61, "R5 empty bits stay set");
        rd(3'd2, 8'h04, "R4 receive outranks transmit");
        rd(3'd0, 8'hA5, "R9 first byte kept");
        rd(3'd5, 8'h60, "R8 data ready cleared");
        rd(3'd2, 8'h02, "R6 pending survived other code");
        rd(3'd2, 8'h01, "R6 cleared after tx code");

        // R10 break, and break over a full holder
        send(8'h11);
        brk();
        rd(3'd5, 8'h71, "R10 break status");
        rd(3'd0, 8'h00, "R10 break byte");
        rd(3'd5, 8'h60, "R8 break cleared");
        check(rx_ready == 1'b1, "R9 ready after drain", rx_ready, 1);

        // R4 transmit pending without its enable
        wr(3'd1, 8'h01);
        wr(3'd0, 8'h99);
        check(irq == 1'b0, "R4 disabled tx gives no irq", irq, 0);
        rd(3'd2, 8'h01, "R4 none when tx disabled");
        wr(3'd1, 8'h03);
        rd(3'd2, 8'h02, "R4 tx code when enabled");

        // R2 divisor-mode read leaves holder untouched
        send(8'h5E);
        wr(3'd3, 8'h80);
        rd(3'd0, 8'h34, "R2 divisor read while full");
        wr(3'd3, 8'h00);
        rd(3'd5, 8'h61, "R2 data ready kept");
        rd(3'd0, 8'h5E, "R8 held byte");

        repeat (2) @(posedge clk);
        @(negedge clk);
        check(tx_exp_q.size() == 0, "R5 all tx strobes seen", tx_exp_q.size(), 0);
        check(rd_exp_q.size() == 0, "R8 all reads seen", rd_exp_q.size(), 0);
        report();
    end
endmodule